// File: doc/BRIEF.md
# DMA Address Hold-Loop Generator

This block produces the byte address for every beat of one DMA channel, one address for the read side and one for the write side. Each side works in one of two ways. It can step linearly, one byte per beat. It can also circle inside a small window of 1, 2, 4 or 8 bytes that begins at its base address, which suits a FIFO-like peripheral register that is read or written repeatedly.

A single mode word selects the behaviour of both sides. A start strobe captures the mode word and both base addresses. From then on, each advance strobe moves both sides forward by one beat. The surrounding channel logic owns the byte count, termination and the bus traffic. It uses the two address outputs as they stand in the cycle after each strobe.

Mode word layout (all other bits are ignored):

| Bits | Meaning |
|---|---|
| 12 | read-side hold enable |
| 13 | write-side hold enable |
| 15:14 | read-side window code (log2 of window bytes) |
| 17:16 | write-side window code (log2 of window bytes) |

Top module: `dma_addr_loop_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, both address outputs read zero.
- R2: One cycle after a start strobe, the read address equals the read base and the write address equals the write base that were presented with that strobe.
- R3: When a side's hold enable bit is clear (read: mode bit 12, write: mode bit 13), each advance raises that side's address by exactly 1.
- R4: When a side's hold enable bit is set with window code k (read: bits 15:14, write: bits 17:16), successive advances give base, base+1, …, base+2^k−1 and then return to base, repeating for as long as advances continue.
- R5: The two sides are independent. Each follows its own base, hold enable and window code, whatever the other side is set to.
- R6: With hold enabled and window code 0, the address stays at the base for every advance.
- R7: In a cycle with neither start nor advance, both addresses keep their values.
- R8: A start and an advance in the same cycle act as a start alone: the outputs show the new bases with zero offset.
- R9: Changes to the mode word or to the base inputs between start strobes have no effect on the address streams.
- R10: Linear addresses wrap modulo 2^ADDR_W. A base of all ones advances to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures mode word and both bases, clears offsets |
| advance | input | 1 | Moves both sides forward by one beat |
| mode_word | input | MODE_W | Channel mode word (fields as listed above) |
| src_base | input | ADDR_W | Read-side base address |
| dst_base | input | ADDR_W | Write-side base address |
| src_addr | output | ADDR_W | Current read-side address |
| dst_addr | output | ADDR_W | Current write-side address |

## Verification
The hardest case is a mode word or base that changes while a transfer is running. The block should ignore it, but because the new value is valid in itself, a design that reads it live looks correct until the stream is compared beat by beat. The stimulus starts a windowed run, then drives a different mode word and different bases on every later advance. The scoreboard keeps expecting the originally captured sequence. Windows are also placed across the top of the address space, and start is raised together with advance, so that carry handling and strobe priority are exercised.

// File: rtl/dma_addr_loop_pkg.sv
package dma_addr_loop_pkg;

    localparam int NUM_SIDES    = 2;
    localparam int SIDE_SRC     = 0;
    localparam int SIDE_DST     = 1;

    localparam int WIN_CODE_W   = 2;
    localparam int WIN_OFF_W    = 3;

    localparam int SRC_HOLD_BIT = 12;
    localparam int DST_HOLD_BIT = 13;
    localparam int SRC_CODE_LSB = 14;
    localparam int DST_CODE_LSB = 16;
    localparam int MODE_TOP_BIT = DST_CODE_LSB + WIN_CODE_W - 1;

    typedef enum logic [WIN_CODE_W-1:0] {
        WIN_1 = 2'd0,
        WIN_2 = 2'd1,
        WIN_4 = 2'd2,
        WIN_8 = 2'd3
    } win_code_e;

    typedef struct packed {
        logic      hold;
        win_code_e code;
    } side_cfg_t;

    function automatic logic [WIN_OFF_W-1:0] win_mask(win_code_e c);
        logic [WIN_OFF_W:0] span;
        span = (WIN_OFF_W+1)'(1) << c;
        return WIN_OFF_W'(span - (WIN_OFF_W+1)'(1));
    endfunction

endpackage

// File: rtl/addr_mode_decode.sv
module addr_mode_decode
    import dma_addr_loop_pkg::*;
#(
    parameter int MODE_W = 32
) (
    input  logic [MODE_W-1:0]               mode_word,
    output side_cfg_t [NUM_SIDES-1:0]       cfg
);

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam int HB = (s == SIDE_SRC) ? SRC_HOLD_BIT : DST_HOLD_BIT;
        localparam int CB = (s == SIDE_SRC) ? SRC_CODE_LSB : DST_CODE_LSB;
        assign cfg[s].hold = mode_word[HB];
        assign cfg[s].code = win_code_e'(mode_word[CB +: WIN_CODE_W]);
    end

    logic mode_unused;
    assign mode_unused = ^{mode_word[MODE_W-1:MODE_TOP_BIT+1], mode_word[SRC_HOLD_BIT-1:0]};

endmodule

// File: rtl/addr_side_gen.sv
module addr_side_gen
    import dma_addr_loop_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base_in,
    input  side_cfg_t         cfg_in,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int HI_W = ADDR_W - WIN_OFF_W;

    logic [ADDR_W-1:0]    base_q;
    logic [ADDR_W-1:0]    off_q;
    logic [ADDR_W-1:0]    off_nxt;
    logic [WIN_OFF_W-1:0] win_step;
    side_cfg_t            cfg_q;

    always_comb begin
        win_step = (off_q[WIN_OFF_W-1:0] + WIN_OFF_W'(1)) & win_mask(cfg_q.code);
        if (cfg_q.hold) begin
            off_nxt = {{HI_W{1'b0}}, win_step};
        end else begin
            off_nxt = off_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            off_q  <= '0;
            cfg_q  <= '0;
        end else if (start) begin
            base_q <= base_in;
            off_q  <= '0;
            cfg_q  <= cfg_in;
        end else if (advance) begin
            off_q  <= off_nxt;
        end
    end

    assign addr_out = base_q + off_q;

    // R2
    base_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> addr_out == $past(base_in));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !advance) |=> $stable(addr_out));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && advance && !cfg_q.hold) |=> addr_out == $past(addr_out) + ADDR_W'(1));

    // R4
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && advance && cfg_q.hold) |=>
            (addr_out - base_q) <= {{HI_W{1'b0}}, win_mask(cfg_q.code)});

    // R6
    single_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && advance && cfg_q.hold && cfg_q.code == WIN_1) |=> $stable(addr_out));

endmodule

// File: rtl/dma_addr_loop_gen.sv
module dma_addr_loop_gen
    import dma_addr_loop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MODE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              advance,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    side_cfg_t [NUM_SIDES-1:0] cfg;
    logic [ADDR_W-1:0]         base_arr [NUM_SIDES];
    logic [ADDR_W-1:0]         addr_arr [NUM_SIDES];

    addr_mode_decode #(.MODE_W(MODE_W)) u_decode (
        .mode_word (mode_word),
        .cfg       (cfg)
    );

    assign base_arr[SIDE_SRC] = src_base;
    assign base_arr[SIDE_DST] = dst_base;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        addr_side_gen #(.ADDR_W(ADDR_W)) u_side (
            .clk      (clk),
            .rst      (rst),
            .start    (start),
            .advance  (advance),
            .base_in  (base_arr[s]),
            .cfg_in   (cfg[s]),
            .addr_out (addr_arr[s])
        );
    end

    assign src_addr = addr_arr[SIDE_SRC];
    assign dst_addr = addr_arr[SIDE_DST];

    // R8
    start_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (start && advance) |=> (src_addr == $past(src_base)) && (dst_addr == $past(dst_base)));

endmodule

// File: tb/dma_addr_loop_gen_tb_top.sv
module dma_addr_loop_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        advance = 1'b0;
    logic [31:0] mode_word = '0;
    logic [31:0] src_base = '0;
    logic [31:0] dst_base = '0;
    logic [31:0] src_addr;
    logic [31:0] dst_addr;

    always #5 clk = ~clk;

    dma_addr_loop_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .advance(advance),
        .mode_word(mode_word), .src_base(src_base), .dst_base(dst_base),
        .src_addr(src_addr), .dst_addr(dst_addr)
    );

    typedef struct {
        logic [31:0] s;
        logic [31:0] d;
        string       tag;
    } exp_t;

    exp_t q[$];
    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [31:0] m_sb = '0, m_db = '0;
    bit          m_sh = 0, m_dh = 0;
    int          m_sc = 0, m_dc = 0;
    int unsigned m_n  = 0;

    function automatic logic [31:0] mk_mode(bit sh, bit dh, int sc, int dc);
        logic [31:0] mw;
        mw = 32'h0000_0000;
        mw[12]    = sh;
        mw[13]    = dh;
        mw[15:14] = 2'(sc);
        mw[17:16] = 2'(dc);
        return mw;
    endfunction

    function automatic logic [31:0] model(logic [31:0] b, bit h, int c, int unsigned n);
        int unsigned sz;
        sz = 1 << c;
        if (h) return b + 32'(n % sz);
        return b + 32'(n);
    endfunction

    task automatic step(bit st, bit adv, logic [31:0] mw,
                        logic [31:0] sb, logic [31:0] db, string tag);
        exp_t e;
        @(negedge clk);
        start = st; advance = adv; mode_word = mw; src_base = sb; dst_base = db;
        @(posedge clk);
        if (st) begin
            m_sb = sb; m_db = db;
            m_sh = mw[12]; m_dh = mw[13];
            m_sc = int'(mw[15:14]); m_dc = int'(mw[17:16]);
            m_n  = 0;
        end else if (adv) begin
            m_n++;
        end
        e.s = model(m_sb, m_sh, m_sc, m_n);
        e.d = model(m_db, m_dh, m_dc, m_n);
        e.tag = tag;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            vectors++;
            if (src_addr !== e.s || dst_addr !== e.d) begin
                fails++;
                $display("FAIL %s: src=%h dst=%h expected src=%h dst=%h",
                         e.tag, src_addr, dst_addr, e.s, e.d);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] mw;
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (src_addr !== 32'h0 || dst_addr !== 32'h0) begin
            fails++;
            $display("FAIL R1: src=%h dst=%h expected 0 0", src_addr, dst_addr);
        end
        rst = 1'b0;
        step(0, 0, '0, '0, '0, "R1");

        // R2 load, R3 linear stepping
        step(1, 0, mk_mode(0, 0, 0, 0), 32'h0000_1000, 32'h0000_2000, "R2");
        for (int i = 0; i < 10; i++) step(0, 1, '0, '0, '0, "R3");
        // R7 idle cycles
        for (int i = 0; i < 3; i++) step(0, 0, '0, '0, '0, "R7");

        // R4 every window code, R6 for code 0, R5 each side its own code
        for (int c = 0; c < 4; c++) begin
            mw = mk_mode(1, 1, c, 3 - c);
            step(1, 0, mw, 32'h0000_4003 + 32'(c), 32'h0008_0010, "R2");
            for (int i = 0; i < 18; i++) begin
                step(0, 1, mw, '0, '0, (c == 0) ? "R6" : "R4");
                if (i == 7) step(0, 0, mw, '0, '0, "R7");
            end
        end

        // R5 read side windowed, write side linear
        mw = mk_mode(1, 0, 2, 3);
        step(1, 0, mw, 32'h0000_0100, 32'h0000_0200, "R5");
        for (int i = 0; i < 12; i++) step(0, 1, mw, '0, '0, "R5");
        // R5 read side linear, write side windowed
        mw = mk_mode(0, 1, 1, 3);
        step(1, 0, mw, 32'h0000_0300, 32'h0000_0405, "R5");
        for (int i = 0; i < 12; i++) step(0, 1, mw, '0, '0, "R5");

        // R9 mode and bases changed mid-run are ignored
        step(1, 0, mk_mode(1, 1, 2, 1), 32'h0000_5000, 32'h0000_6000, "R9");
        for (int i = 0; i < 12; i++)
            step(0, 1, mk_mode(i[0], ~i[0], i % 4, 3), 32'hDEAD_0000 + 32'(i),
                 32'hBEEF_0000 + 32'(i), "R9");

        // R8 start and advance together
        for (int i = 0; i < 3; i++) step(0, 1, '0, '0, '0, "R9");
        step(1, 1, mk_mode(1, 0, 3, 0), 32'h0000_7000, 32'h0000_8000, "R8");
        for (int i = 0; i < 4; i++) step(0, 1, '0, '0, '0, "R8");

        // R10 linear wrap at the top of the address space
        step(1, 0, mk_mode(0, 1, 0, 2), 32'hFFFF_FFFE, 32'hFFFF_FFFE, "R10");
        for (int i = 0; i < 6; i++) step(0, 1, '0, '0, '0, "R10");

        @(negedge clk);
        start = 1'b0; advance = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule